// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for a small core that runs several software processes. It holds four fully associative entries, each made of a virtual tag word and a physical page word, over 4 KB pages. Software loads the entries itself by storing words into a small memory-mapped window. The block never walks page tables and never picks a victim entry.

Each lookup presents a virtual address, a store flag, the running process number and the user-mode flag. The process number is folded into the unused page-offset bits of the tag. Bit 0 of the tag grants permission to store. Kernel-mode accesses, and all accesses by process 0, pass through untranslated. A lookup that finds no entry raises a miss in the same cycle. On the next clock edge it records the faulting page address and raises a one-cycle interrupt pulse.

Top module: `pt_xlat_tlb`

## Requirements
- R1: A configuration store at address WIN_BASE + 8*i (default WIN_BASE = 0x200000A0) loads the tag word of entry i, and a store at WIN_BASE + 8*i + 4 loads its physical word, for i from 0 to 3. Stores outside WIN_BASE to WIN_BASE+31, or with address bits [1:0] not zero, change no entry.
- R2: The lookup key is the virtual address with bits [11:0] cleared, ORed with the process number shifted left by one. An entry matches when its tag word with bit 0 forced to 0 equals that key.
- R3: Tag bit 0 is the store permission. A store lookup (lk_write=1) matches only entries whose tag bit 0 is 1. A load lookup ignores that bit.
- R4: On a match, lk_paddr equals bits [31:12] of the matching entry's physical word, followed by bits [11:0] of the virtual address.
- R5: When lk_pid is 0 or lk_user is 0, lk_paddr equals lk_vaddr and lk_miss stays 0.
- R6: When lk_valid=1, translation is active and no entry matches, lk_miss is 1 in the same cycle and lk_paddr equals lk_vaddr.
- R7: At the clock edge that ends a missing lookup, fault_addr takes the virtual address with bits [11:0] cleared. fault_addr holds that value until the next missing lookup.
- R8: mmu_irq is 1 for exactly the one cycle after each cycle with a missing lookup, and 0 otherwise.
- R9: When several entries match, the lowest-numbered entry supplies the physical page.
- R10: Reset clears every tag and physical word, fault_addr and mmu_irq. A translated lookup after reset misses until software loads an entry.
- R11: With lk_valid=0 no miss is raised, fault_addr keeps its value and mmu_irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration store strobe |
| cfg_addr | input | 32 | Configuration store byte address |
| cfg_wdata | input | 32 | Configuration store data |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a store |
| lk_pid | input | 8 | Current process number |
| lk_user | input | 1 | Core is in user mode |
| lk_paddr | output | 32 | Translated or pass-through address |
| lk_miss | output | 1 | Combinational miss / exception |
| fault_addr | output | 32 | Page address of the last miss |
| mmu_irq | output | 1 | One-cycle miss interrupt pulse |

## Verification
The assertions assume that the lookup inputs are settled before each rising edge, and that a miss is judged against the entries as they stood before any configuration store in the same cycle. The bench applies configuration stores and lookups in separate cycles, so a lookup never races an entry update. Random tags use a few pages and process numbers 1 to 3, so hits, permission refusals, cross-process misses and multiple matches all occur. Directed cases cover reset, rejected window stores and priority between duplicate entries.

// File: rtl/pt_xlat_pkg.sv
package pt_xlat_pkg;

   // selects which word of an entry a window store targets
   typedef enum logic {
      FLD_TAG  = 1'b0,
      FLD_PAGE = 1'b1
   } xlat_fld_e;

   // ceil(log2(n)), never below 1, for index widths
   function automatic int idx_width(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/pt_xlat_win_dec.sv
module pt_xlat_win_dec
   import pt_xlat_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          N_ENT    = 4,
   parameter logic [31:0] WIN_BASE = 32'h2000_00A0
) (
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   output logic [N_ENT-1:0]  ent_we,
   output xlat_fld_e         fld
);
   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(N_ENT * 8);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

   logic [ADDR_W-1:0] offs;
   logic [ADDR_W-1:0] slot;
   logic              in_win;

   always_comb begin
      offs   = cfg_addr - BASE;
      slot   = offs >> 3;
      in_win = (cfg_addr >= BASE) && (offs < SPAN) && (cfg_addr[1:0] == 2'b00);
      fld    = offs[2] ? FLD_PAGE : FLD_TAG;
   end

   for (genvar i = 0; i < N_ENT; i++) begin : g_sel
      assign ent_we[i] = cfg_we && in_win && (slot == ADDR_W'(i));
   end

endmodule

// File: rtl/pt_xlat_entry.sv
module pt_xlat_entry
   import pt_xlat_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   localparam int PG_W     = ADDR_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  xlat_fld_e         fld,
   input  logic [ADDR_W-1:0] wdata,
   input  logic [ADDR_W-1:0] key,
   input  logic              lk_write,
   output logic              hit,
   output logic [PG_W-1:0]   page
);
   logic [ADDR_W-1:0] tag_q;
   logic [PG_W-1:0]   page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q  <= '0;
         page_q <= '0;
      end else if (we) begin
         if (fld == FLD_TAG) tag_q <= wdata;
         else                page_q <= wdata[ADDR_W-1:PAGE_BITS];
      end
   end

   always_comb begin
      hit  = ({tag_q[ADDR_W-1:1], 1'b0} == key) && (!lk_write || tag_q[0]);
      page = page_q;
   end

endmodule

// File: rtl/pt_xlat_pick.sv
module pt_xlat_pick #(
   parameter int N_ENT = 4,
   parameter int PG_W  = 20
) (
   input  logic [N_ENT-1:0]           hits,
   input  logic [N_ENT-1:0][PG_W-1:0] pages,
   output logic                       any_hit,
   output logic [PG_W-1:0]            page_sel
);
   always_comb begin
      any_hit  = |hits;
      page_sel = '0;
      // scan downward so the lowest matching index is written last
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (hits[i]) page_sel = pages[i];
      end
   end
endmodule

// File: rtl/pt_xlat_tlb.sv
module pt_xlat_tlb
   import pt_xlat_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          N_ENT     = 4,
   parameter int          PAGE_BITS = 12,
   parameter int          PID_W     = 8,
   parameter logic [31:0] WIN_BASE  = 32'h2000_00A0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_vaddr,
   input  logic              lk_write,
   input  logic [PID_W-1:0]  lk_pid,
   input  logic              lk_user,
   output logic [ADDR_W-1:0] lk_paddr,
   output logic              lk_miss,
   output logic [ADDR_W-1:0] fault_addr,
   output logic              mmu_irq
);
   localparam int PG_W = ADDR_W - PAGE_BITS;

   if (PID_W + 1 > PAGE_BITS) begin : g_bad_pid
      $error("process number does not fit in the page offset");
   end
   if (N_ENT < 1) begin : g_bad_ent
      $error("need at least one entry");
   end
   if (WIN_BASE[2:0] != 3'b000) begin : g_bad_base
      $error("window base must be 8-byte aligned");
   end

   xlat_fld_e                   fld;
   logic [N_ENT-1:0]            ent_we;
   logic [N_ENT-1:0]            hits;
   logic [N_ENT-1:0][PG_W-1:0]  pages;
   logic [ADDR_W-1:0]           key;
   logic [PAGE_BITS-1:0]        key_lo;
   logic                        any_hit;
   logic [PG_W-1:0]             page_sel;
   logic                        xlate_en;

   pt_xlat_win_dec #(
      .ADDR_W(ADDR_W), .N_ENT(N_ENT), .WIN_BASE(WIN_BASE)
   ) u_dec (
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .ent_we(ent_we), .fld(fld)
   );

   always_comb begin
      key_lo          = '0;
      key_lo[PID_W:1] = lk_pid;
      key             = {lk_vaddr[ADDR_W-1:PAGE_BITS], key_lo};
      xlate_en        = lk_user && (lk_pid != '0);
   end

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      pt_xlat_entry #(
         .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
      ) u_ent (
         .clk(clk), .rst_n(rst_n), .we(ent_we[i]), .fld(fld),
         .wdata(cfg_wdata), .key(key), .lk_write(lk_write),
         .hit(hits[i]), .page(pages[i])
      );
   end

   pt_xlat_pick #(
      .N_ENT(N_ENT), .PG_W(PG_W)
   ) u_pick (
      .hits(hits), .pages(pages), .any_hit(any_hit), .page_sel(page_sel)
   );

   always_comb begin
      lk_miss  = lk_valid && xlate_en && !any_hit;
      lk_paddr = (xlate_en && any_hit) ? {page_sel, lk_vaddr[PAGE_BITS-1:0]} : lk_vaddr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_addr <= '0;
         mmu_irq    <= 1'b0;
      end else begin
         mmu_irq <= lk_miss;
         if (lk_miss) fault_addr <= {lk_vaddr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      end
   end

endmodule

// File: rtl/pt_xlat_chk.sv
module pt_xlat_chk #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int PID_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [ADDR_W-1:0] lk_vaddr,
   input logic [PID_W-1:0]  lk_pid,
   input logic              lk_user,
   input logic [ADDR_W-1:0] lk_paddr,
   input logic              lk_miss,
   input logic [ADDR_W-1:0] fault_addr,
   input logic              mmu_irq
);
   // R5: kernel mode or process 0 passes through
   a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_user || lk_pid == '0) |-> (lk_paddr == lk_vaddr && !lk_miss));

   // R4: the page offset is never translated
   a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
      lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

   // R6 and R11: a miss needs a valid translated lookup, and keeps the address
   a_r6_miss_cond: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> (lk_valid && lk_user && lk_pid != '0 && lk_paddr == lk_vaddr));

   // R7: the fault address is the page of the missing lookup
   a_r7_fault: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |=> (fault_addr[ADDR_W-1:PAGE_BITS] == $past(lk_vaddr[ADDR_W-1:PAGE_BITS])
                   && fault_addr[PAGE_BITS-1:0] == '0));

   // R7: without a miss the fault address holds
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_miss |=> $stable(fault_addr));

   // R8: the interrupt follows each missing cycle by exactly one cycle
   a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |=> mmu_irq);
   a_r8_only: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_miss |=> !mmu_irq);

   // R10: reset leaves the interrupt low
   a_r10_reset: assert property (@(posedge clk)
      !rst_n |=> !mmu_irq);
endmodule

bind pt_xlat_tlb pt_xlat_chk #(
   .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
   .lk_pid(lk_pid), .lk_user(lk_user), .lk_paddr(lk_paddr),
   .lk_miss(lk_miss), .fault_addr(fault_addr), .mmu_irq(mmu_irq)
);

// File: tb/pt_xlat_tlb_tb.sv
module pt_xlat_tlb_tb_top;
   localparam logic [31:0] BASE = 32'h2000_00A0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_write = 1'b0;
   logic [7:0]  lk_pid = '0;
   logic        lk_user = 1'b0;
   logic [31:0] lk_paddr;
   logic        lk_miss;
   logic [31:0] fault_addr;
   logic        mmu_irq;

   always #10 clk = ~clk;   // 50 MHz

   pt_xlat_tlb dut_i (.*);

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   logic [31:0] m_tag [4];
   logic [31:0] m_phys[4];
   logic [31:0] m_fault;
   logic        m_irq;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         summary();
      end
   end

   // expected {miss, paddr} from the requirements
   function automatic logic [32:0] exp_xlat(input logic valid, input logic [31:0] va,
                                            input logic wr, input logic [7:0] pid,
                                            input logic user);
      logic [31:0] key;
      if (!user || pid == 8'd0) return {1'b0, va};                 // R5
      key = {va[31:12], 12'h000} | ({24'd0, pid} << 1);            // R2
      for (int i = 0; i < 4; i++) begin                            // R9 lowest first
         if ((m_tag[i] & 32'hFFFF_FFFE) == key && (!wr || m_tag[i][0]))  // R3
            return {1'b0, m_phys[i][31:12], va[11:0]};             // R4
      end
      return {valid, va};                                          // R6
   endfunction

   task automatic cfg_store(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      lk_valid = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      if (a >= BASE && a < BASE + 32 && a[1:0] == 2'b00) begin     // R1
         if (a[2]) m_phys[(a - BASE) >> 3] = d;
         else      m_tag [(a - BASE) >> 3] = d;
      end
      m_irq = 1'b0;
   endtask

   task automatic lookup(input string req, input logic v, input logic [31:0] va,
                         input logic wr, input logic [7:0] pid, input logic user);
      logic [32:0] e;
      @(negedge clk);
      lk_valid = v; lk_vaddr = va; lk_write = wr; lk_pid = pid; lk_user = user;
      e = exp_xlat(v, va, wr, pid, user);
      #2;
      check({req, " paddr"}, lk_paddr, e[31:0]);
      check({req, " miss R6"}, {31'd0, lk_miss}, {31'd0, e[32]});
      @(posedge clk); #1;
      if (e[32]) m_fault = {va[31:12], 12'h000};
      m_irq = e[32];
      check({req, " fault R7"}, fault_addr, m_fault);
      check({req, " irq R8"}, {31'd0, mmu_irq}, {31'd0, m_irq});
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 4; i++) begin m_tag[i] = '0; m_phys[i] = '0; end
      m_fault = '0; m_irq = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset fault", fault_addr, 32'h0);
      check("R10 reset irq", {31'd0, mmu_irq}, 32'h0);
      rst_n = 1'b1;

      // R10: empty table misses for a translated lookup
      lookup("R10 empty", 1'b1, 32'h0000_0123, 1'b0, 8'd1, 1'b1);
      // R8: a following hit-free cycle drops the pulse
      lookup("R8 drop", 1'b0, 32'h0000_0123, 1'b0, 8'd1, 1'b1);
      // R5: bypass cases
      lookup("R5 kernel", 1'b1, 32'hDEAD_BEEF, 1'b1, 8'd4, 1'b0);
      lookup("R5 pid0", 1'b1, 32'h1234_5678, 1'b0, 8'd0, 1'b1);
      // R11: invalid lookup raises nothing and keeps fault
      lookup("R11 idle", 1'b0, 32'hABCD_E000, 1'b0, 8'd2, 1'b1);

      // R1 / R2 / R4: load entry 1 for pid 2, page 0x40001, store allowed
      cfg_store(BASE + 8,  32'h4000_1000 | (32'd2 << 1) | 32'd1);
      cfg_store(BASE + 12, 32'h0777_7ABC);
      lookup("R4 hit", 1'b1, 32'h4000_1F0E, 1'b1, 8'd2, 1'b1);
      lookup("R2 other pid", 1'b1, 32'h4000_1F0E, 1'b0, 8'd3, 1'b1);
      // R1: misaligned and out-of-window stores are ignored
      cfg_store(BASE + 10, 32'h5000_0000 | (32'd2 << 1));
      cfg_store(BASE + 32, 32'h5000_0000 | (32'd2 << 1));
      cfg_store(BASE - 8,  32'h5000_0000 | (32'd2 << 1));
      lookup("R1 ignored store", 1'b1, 32'h5000_0004, 1'b0, 8'd2, 1'b1);
      lookup("R1 entry kept", 1'b1, 32'h4000_1004, 1'b0, 8'd2, 1'b1);
      // R3: read-only entry 3
      cfg_store(BASE + 24, 32'h6000_0000 | (32'd2 << 1));
      cfg_store(BASE + 28, 32'h0012_3000);
      lookup("R3 load ok", 1'b1, 32'h6000_0010, 1'b0, 8'd2, 1'b1);
      lookup("R3 store refused", 1'b1, 32'h6000_0010, 1'b1, 8'd2, 1'b1);
      // R9: entries 0 and 2 both match; entry 0 wins
      cfg_store(BASE + 16, 32'h7000_0000 | (32'd2 << 1) | 32'd1);
      cfg_store(BASE + 20, 32'h0AAA_A000);
      cfg_store(BASE + 0,  32'h7000_0000 | (32'd2 << 1) | 32'd1);
      cfg_store(BASE + 4,  32'h0BBB_B000);
      lookup("R9 priority", 1'b1, 32'h7000_0ABC, 1'b0, 8'd2, 1'b1);
      check("R9 priority page", lk_paddr, 32'h0BBB_BABC);

      // constrained random rounds
      for (int r = 0; r < 40; r++) begin
         for (int k = 0; k < 3; k++) begin
            logic [31:0] a;
            logic [31:0] d;
            a = BASE + 32'($urandom_range(0, 7) * 4);
            if ($urandom_range(0, 9) == 0) a = a + 32'($urandom_range(1, 3));
            if (a[2]) d = $urandom;
            else d = {12'h100, 6'd0, 2'($urandom_range(0, 3)), 12'h000}
                     | ({24'd0, 8'($urandom_range(1, 3))} << 1) | 32'($urandom_range(0, 1));
            cfg_store(a, d);
         end
         for (int k = 0; k < 40; k++) begin
            logic [31:0] va;
            va = {12'h100, 6'd0, 2'($urandom_range(0, 3)), 12'($urandom)};
            if ($urandom_range(0, 7) == 0) va = $urandom;
            lookup("R2 R3 R4 R6 random", $urandom_range(0, 7) != 0, va,
                   1'($urandom_range(0, 1)), 8'($urandom_range(0, 3)),
                   $urandom_range(0, 5) != 0);
         end
      end

      done = 1;
      summary();
   end
endmodule